// File: doc/BRIEF.md
# Dual-Port Byte-Lane Static Memory

This block is a true two-port word memory built from synthesizable logic. Two fully independent access ports, called left and right, share one storage array and one clock. Each port has its own address, write data, read data and a two-bit read-valid vector, plus a set of active-low and active-high control inputs. Both ports may reach any word in the same cycle, including the same word.

A port does something only when its pair of chip selects agrees: the low-active select low and the high-active select high. Each port then decodes a read or a write. The 16-bit word is split into an upper and a lower byte lane, and each lane is enabled on its own by a low-active lane select. A low-active flag select takes the access away from the array altogether, so a port can address its flag logic without touching stored data. Read data is registered. It appears one cycle after the access and carries a per-lane valid bit. A lane that is not valid reads as zero, which stands in for an undriven bus.

The depth is 2**ADDR_W words. ADDR_W = 15 gives the full 32768-word array with a 15-bit address. The default of 11 keeps elaboration small.

Top module: `dpm_dual_port_mem`

## Requirements
- R1: While rst_n is low at a clock edge, both read-valid vectors and both read-data buses are zero in the following cycle, whatever the port controls are. The array contents are not cleared.
- R2: A port is selected only when its cs0_n input is 0 and its cs1 input is 1. With any other combination, that port neither writes the array nor produces read-valid bits.
- R3: Lane select hi_n gates data bits 15..8 (read-valid bit 1) and lo_n gates bits 7..0 (read-valid bit 0). A lane takes part in an access only when its select is 0, and with both selects at 1 the access does nothing.
- R4: A selected port with wr_n = 0 and flag_n = 1 writes its write data into the lanes whose select is 0, at the addressed word. The value of oe_n makes no difference, and a write produces no read-valid bits.
- R5: A selected port with wr_n = 1, oe_n = 0 and flag_n = 1 returns the addressed word one cycle later. A selected lane has its valid bit set to 1 and its data shown. An unselected lane has valid 0 and data 0.
- R6: With oe_n = 1, a port produces no read-valid bits, whatever its other controls are.
- R7: With flag_n = 0, a port neither reads nor writes the array.
- R8: The two ports work independently. Both may read the same word in the same cycle, and a word written by one port is read back by the other.
- R9: When both ports write the same lane of the same word in the same cycle, the left port's data is stored. Different lanes written by the two ports in one cycle are both stored.
- R10: A read in the same cycle as the other port's write to the same word returns the word as it was before that write.
- R11: Every address from 0 up to 2**ADDR_W - 1 is usable, including the top word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read stages |
| lft_cs0_n | input | 1 | Left select, active low |
| lft_cs1 | input | 1 | Left select, active high |
| lft_wr_n | input | 1 | Left direction: 0 write, 1 read |
| lft_oe_n | input | 1 | Left read output enable, active low |
| lft_hi_n | input | 1 | Left upper-lane select, active low |
| lft_lo_n | input | 1 | Left lower-lane select, active low |
| lft_flag_n | input | 1 | Left flag select, active low; diverts the access from the array |
| lft_addr | input | ADDR_W | Left word address |
| lft_wdata | input | DATA_W | Left write data |
| lft_rdata | output | DATA_W | Left read data, invalid lanes zero |
| lft_rvalid | output | LANES | Left per-lane read valid (bit 1 upper, bit 0 lower) |
| rgt_cs0_n | input | 1 | Right select, active low |
| rgt_cs1 | input | 1 | Right select, active high |
| rgt_wr_n | input | 1 | Right direction: 0 write, 1 read |
| rgt_oe_n | input | 1 | Right read output enable, active low |
| rgt_hi_n | input | 1 | Right upper-lane select, active low |
| rgt_lo_n | input | 1 | Right lower-lane select, active low |
| rgt_flag_n | input | 1 | Right flag select, active low; diverts the access from the array |
| rgt_addr | input | ADDR_W | Right word address |
| rgt_wdata | input | DATA_W | Right write data |
| rgt_rdata | output | DATA_W | Right read data, invalid lanes zero |
| rgt_rvalid | output | LANES | Right per-lane read valid (bit 1 upper, bit 0 lower) |

## Verification
The embedded assertions check the control side on every cycle. A deselected port, a raised oe_n, a write or a low flag select must leave the next cycle's valid bits at zero. A valid bit must always trace back to a lane that was requested. A qualified read must raise exactly the lanes whose selects were low. The data side can only be shown by the bench scenarios. These cover writes masked by lane, writes blocked by deselection or by the flag select, left-wins collisions, merges of different lanes, read-before-write ordering across the ports, and the top address.

// File: rtl/dpm_pkg.sv
// Package dpm_pkg
// Holds the shared lane geometry and the access-kind encoding that the port
// decoders produce. Assumes the data word is a whole number of byte lanes.
package dpm_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_FLAG  = 2'd3
    } acc_kind_t;

endpackage

// File: rtl/dpm_port_decode.sv
// Module dpm_port_decode
// Turns one port's raw control pins into an access kind and per-lane read and
// write enables. Purely combinational. Assumes lane_sel_n holds one active-low
// select per lane, with bit 0 as the lowest lane.
module dpm_port_decode
    import dpm_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             cs0_n,
    input  logic             cs1,
    input  logic             wr_n,
    input  logic             oe_n,
    input  logic             flag_n,
    input  logic [LANES-1:0] lane_sel_n,
    output acc_kind_t        kind,
    output logic [LANES-1:0] wr_en,
    output logic [LANES-1:0] rd_en
);

    logic port_sel;

    // Port is live only when both chip selects agree.
    always_comb begin
        port_sel = !cs0_n && cs1;
    end

    // Classify the access; the flag select takes priority over the array.
    always_comb begin
        if (!port_sel) begin
            kind = ACC_IDLE;
        end else if (!flag_n) begin
            kind = ACC_FLAG;
        end else if (!wr_n) begin
            kind = ACC_WRITE;
        end else if (!oe_n) begin
            kind = ACC_READ;
        end else begin
            kind = ACC_IDLE;
        end
    end

    // Spread the access kind over the lanes whose select is low.
    always_comb begin
        wr_en = '0;
        rd_en = '0;
        for (int i = 0; i < LANES; i++) begin
            wr_en[i] = (kind == ACC_WRITE) && !lane_sel_n[i];
            rd_en[i] = (kind == ACC_READ)  && !lane_sel_n[i];
        end
    end

endmodule

// File: rtl/dpm_lane_bank.sv
// Module dpm_lane_bank
// Storage for one byte lane, with two write ports and two registered read ports.
// When both ports write the same word in one cycle, the left port's write is
// applied last and so is kept. Reads return the contents from before the
// current cycle's writes. Assumes no reset of the storage itself.
module dpm_lane_bank #(
    parameter int ADDR_W = 11,
    parameter int WIDTH  = 8
) (
    input  logic              clk,
    input  logic              l_we,
    input  logic              l_re,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [WIDTH-1:0]  l_wd,
    output logic [WIDTH-1:0]  l_q,
    input  logic              r_we,
    input  logic              r_re,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [WIDTH-1:0]  r_wd,
    output logic [WIDTH-1:0]  r_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    // Apply the writes, right first so that the left port wins a collision.
    always_ff @(posedge clk) begin
        if (r_we) begin
            mem[r_addr] <= r_wd;
        end
        if (l_we) begin
            mem[l_addr] <= l_wd;
        end
    end

    // Capture the left read word (the value from before this cycle's writes).
    always_ff @(posedge clk) begin
        if (l_re) begin
            l_q <= mem[l_addr];
        end
    end

    // Capture the right read word (the value from before this cycle's writes).
    always_ff @(posedge clk) begin
        if (r_re) begin
            r_q <= mem[r_addr];
        end
    end

endmodule

// File: rtl/dpm_read_stage.sv
// Module dpm_read_stage
// Registers one port's per-lane read-valid bits and forces the data of
// invalid lanes to zero. Assumes q holds the lane words captured at the same
// edge that the enables were sampled.
module dpm_read_stage #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        rd_en,
    input  logic [LANES*LANE_W-1:0] q,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        rvalid
);

    logic [LANES-1:0] valid_q;

    // Track which lanes were read on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= rd_en;
        end
    end

    assign rvalid = valid_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Show a lane's word only while that lane is valid.
        always_comb begin
            rdata[g*LANE_W +: LANE_W] = valid_q[g] ? q[g*LANE_W +: LANE_W] : '0;
        end

        // R5: a valid lane must come from a lane enable on the previous cycle.
        p_valid_from_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[g] |-> $past(rd_en[g]));
    end

endmodule

// File: rtl/dpm_dual_port_mem.sv
// Module dpm_dual_port_mem
// Two independent ports, left and right, on a shared array of 2**ADDR_W words.
// The word is split into byte lanes, and each lane is gated separately for reads
// and writes. Both ports are sampled on one clock, and read data follows one
// cycle after the access. Assumes DATA_W is a multiple of the lane width.
module dpm_dual_port_mem
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_cs0_n,
    input  logic              lft_cs1,
    input  logic              lft_wr_n,
    input  logic              lft_oe_n,
    input  logic              lft_hi_n,
    input  logic              lft_lo_n,
    input  logic              lft_flag_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic [DATA_W-1:0] lft_wdata,
    output logic [DATA_W-1:0] lft_rdata,
    output logic [1:0]        lft_rvalid,
    input  logic              rgt_cs0_n,
    input  logic              rgt_cs1,
    input  logic              rgt_wr_n,
    input  logic              rgt_oe_n,
    input  logic              rgt_hi_n,
    input  logic              rgt_lo_n,
    input  logic              rgt_flag_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic [DATA_W-1:0] rgt_wdata,
    output logic [DATA_W-1:0] rgt_rdata,
    output logic [1:0]        rgt_rvalid
);

    localparam int LANES = DATA_W / LANE_W;

    acc_kind_t        l_kind, r_kind;
    logic [LANES-1:0] l_wr_en, l_rd_en, r_wr_en, r_rd_en;
    logic [DATA_W-1:0] l_q, r_q;

    dpm_port_decode #(.LANES(LANES)) u_dec_l (
        .cs0_n      (lft_cs0_n),
        .cs1        (lft_cs1),
        .wr_n       (lft_wr_n),
        .oe_n       (lft_oe_n),
        .flag_n     (lft_flag_n),
        .lane_sel_n ({lft_hi_n, lft_lo_n}),
        .kind       (l_kind),
        .wr_en      (l_wr_en),
        .rd_en      (l_rd_en)
    );

    dpm_port_decode #(.LANES(LANES)) u_dec_r (
        .cs0_n      (rgt_cs0_n),
        .cs1        (rgt_cs1),
        .wr_n       (rgt_wr_n),
        .oe_n       (rgt_oe_n),
        .flag_n     (rgt_flag_n),
        .lane_sel_n ({rgt_hi_n, rgt_lo_n}),
        .kind       (r_kind),
        .wr_en      (r_wr_en),
        .rd_en      (r_rd_en)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        dpm_lane_bank #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_bank (
            .clk    (clk),
            .l_we   (l_wr_en[g]),
            .l_re   (l_rd_en[g]),
            .l_addr (lft_addr),
            .l_wd   (lft_wdata[g*LANE_W +: LANE_W]),
            .l_q    (l_q[g*LANE_W +: LANE_W]),
            .r_we   (r_wr_en[g]),
            .r_re   (r_rd_en[g]),
            .r_addr (rgt_addr),
            .r_wd   (rgt_wdata[g*LANE_W +: LANE_W]),
            .r_q    (r_q[g*LANE_W +: LANE_W])
        );
    end

    dpm_read_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_l (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (l_rd_en),
        .q      (l_q),
        .rdata  (lft_rdata),
        .rvalid (lft_rvalid)
    );

    dpm_read_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_r (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (r_rd_en),
        .q      (r_q),
        .rdata  (rgt_rdata),
        .rvalid (rgt_rvalid)
    );

    // R2: a deselected port yields no valid lanes on the next cycle.
    p_deselect_quiet_l_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lft_cs0_n || !lft_cs1) |-> (lft_rvalid == '0));
    p_deselect_quiet_r_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rgt_cs0_n || !rgt_cs1) |-> (rgt_rvalid == '0));

    // R3: an unselected lane never turns valid.
    p_hi_lane_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lft_hi_n) |-> !lft_rvalid[1]);
    p_lo_lane_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rgt_lo_n) |-> !rgt_rvalid[0]);

    // R4: a write cycle produces no read data.
    p_write_no_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!lft_wr_n) |-> (lft_rvalid == '0));

    // R5: a qualified read raises exactly the requested lanes.
    p_read_lanes_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!lft_cs0_n && lft_cs1 && lft_wr_n && !lft_oe_n && lft_flag_n))
        |-> (lft_rvalid == ~$past({lft_hi_n, lft_lo_n})));
    p_read_lanes_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!rgt_cs0_n && rgt_cs1 && rgt_wr_n && !rgt_oe_n && rgt_flag_n))
        |-> (rgt_rvalid == ~$past({rgt_hi_n, rgt_lo_n})));

    // R6: output enable high suppresses read data.
    p_oe_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rgt_oe_n) |-> (rgt_rvalid == '0));

    // R7: the flag select keeps the access off the array.
    p_flag_diverts_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!lft_flag_n) |-> (lft_rvalid == '0));
    p_flag_diverts_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rgt_flag_n) |-> (rgt_rvalid == '0));

endmodule

// File: tb/dpm_dual_port_mem_tb.sv
// Bench for dpm_dual_port_mem: a vector table of single-port operations,
// followed by directed two-port, collision and reset cases.
module dpm_dual_port_mem_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 16;

    typedef struct packed {
        logic          cs0_n;
        logic          cs1;
        logic          wr_n;
        logic          oe_n;
        logic          hi_n;
        logic          lo_n;
        logic          flag_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } ctl_t;

    typedef struct packed {
        logic          port;   // 0 left, 1 right
        ctl_t          c;
        logic [1:0]    ev;
        logic [DW-1:0] ed;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 11'd5,   16'hA1B2}, 2'b00, 16'h0000, 4'd4},  // R4 write, oe_n low ignored
        '{1'b0, '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 11'd5,   16'h0000}, 2'b11, 16'hA1B2, 4'd5},  // R5
        '{1'b1, '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 11'd5,   16'h0000}, 2'b11, 16'hA1B2, 4'd8},  // R8 other port
        '{1'b1, '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 11'd5,   16'h5566}, 2'b00, 16'h0000, 4'd3},  // R3 upper only
        '{1'b0, '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 11'd5,   16'h0000}, 2'b11, 16'h55B2, 4'd3},  // R3
        '{1'b0, '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 11'd5,   16'h0000}, 2'b10, 16'h5500, 4'd5},  // R5 upper read
        '{1'b1, '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 11'd5,   16'h0000}, 2'b01, 16'h00B2, 4'd5},  // R5 lower read
        '{1'b0, '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1, 11'd5,   16'h0000}, 2'b00, 16'h0000, 4'd3},  // R3 no lanes
        '{1'b0, '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 11'd5,   16'hFFFF}, 2'b00, 16'h0000, 4'd2},  // R2 cs0_n high
        '{1'b0, '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 11'd5,   16'hFFFF}, 2'b00, 16'h0000, 4'd2},  // R2 cs1 low
        '{1'b0, '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 11'd5,   16'h0000}, 2'b11, 16'h55B2, 4'd2},  // R2 writes ignored
        '{1'b0, '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 11'd5,   16'h0000}, 2'b00, 16'h0000, 4'd2},  // R2 read deselected
        '{1'b0, '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 11'd5,   16'h0000}, 2'b00, 16'h0000, 4'd6},  // R6
        '{1'b1, '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 11'd5,   16'h1234}, 2'b00, 16'h0000, 4'd7},  // R7 flag write
        '{1'b1, '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 11'd5,   16'h0000}, 2'b00, 16'h0000, 4'd7},  // R7 flag read
        '{1'b1, '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 11'd5,   16'h0000}, 2'b11, 16'h55B2, 4'd7},  // R7 array intact
        '{1'b1, '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 11'h7FF, 16'h00C3}, 2'b00, 16'h0000, 4'd11}, // R11 top word
        '{1'b0, '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 11'h7FF, 16'h0000}, 2'b01, 16'h00C3, 4'd11}  // R11
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    ctl_t lc, rc;
    logic [DW-1:0] lft_rdata, rgt_rdata;
    logic [1:0] lft_rvalid, rgt_rvalid;
    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic ctl_t idle();
        return '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0};
    endfunction

    function automatic ctl_t rd(input logic [AW-1:0] a, input logic h, input logic l);
        return '{1'b0, 1'b1, 1'b1, 1'b0, h, l, 1'b1, a, '0};
    endfunction

    function automatic ctl_t wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                input logic h, input logic l);
        return '{1'b0, 1'b1, 1'b0, 1'b1, h, l, 1'b1, a, d};
    endfunction

    dpm_dual_port_mem #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lft_cs0_n  (lc.cs0_n),
        .lft_cs1    (lc.cs1),
        .lft_wr_n   (lc.wr_n),
        .lft_oe_n   (lc.oe_n),
        .lft_hi_n   (lc.hi_n),
        .lft_lo_n   (lc.lo_n),
        .lft_flag_n (lc.flag_n),
        .lft_addr   (lc.addr),
        .lft_wdata  (lc.wdata),
        .lft_rdata  (lft_rdata),
        .lft_rvalid (lft_rvalid),
        .rgt_cs0_n  (rc.cs0_n),
        .rgt_cs1    (rc.cs1),
        .rgt_wr_n   (rc.wr_n),
        .rgt_oe_n   (rc.oe_n),
        .rgt_hi_n   (rc.hi_n),
        .rgt_lo_n   (rc.lo_n),
        .rgt_flag_n (rc.flag_n),
        .rgt_addr   (rc.addr),
        .rgt_wdata  (rc.wdata),
        .rgt_rdata  (rgt_rdata),
        .rgt_rvalid (rgt_rvalid)
    );

    task automatic chk(input string req, input logic [1:0] gv, input logic [DW-1:0] gd,
                       input logic [1:0] ev, input logic [DW-1:0] ed);
        tests++;
        if (gv !== ev || gd !== ed) begin
            fails++;
            $display("FAIL %s: got valid=%b data=%h, expected valid=%b data=%h",
                     req, gv, gd, ev, ed);
        end
    endtask

    // Drive both ports for one edge, then go idle; outputs are sampled on return.
    task automatic cyc(input ctl_t l, input ctl_t r);
        @(negedge clk);
        lc = l;
        rc = r;
        @(negedge clk);
        lc = idle();
        rc = idle();
    endtask

    initial begin
        int cnt = 0;
        while (cnt < 20000) begin
            @(posedge clk);
            cnt++;
        end
        fails++;
        tests++;
        $display("FAIL watchdog: got no finish, expected finish within 20000 cycles");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        lc = idle();
        rc = idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", lft_rvalid, lft_rdata, 2'b00, 16'h0000);
        chk("R1", rgt_rvalid, rgt_rdata, 2'b00, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].port == 1'b0) begin
                cyc(VECS[i].c, idle());
                chk($sformatf("R%0d", VECS[i].req), lft_rvalid, lft_rdata, VECS[i].ev, VECS[i].ed);
            end else begin
                cyc(idle(), VECS[i].c);
                chk($sformatf("R%0d", VECS[i].req), rgt_rvalid, rgt_rdata, VECS[i].ev, VECS[i].ed);
            end
        end

        // R9: same lanes, same word, same cycle -> left data kept
        cyc(wr(11'd9, 16'h1111, 1'b0, 1'b0), wr(11'd9, 16'h2222, 1'b0, 1'b0));
        cyc(rd(11'd9, 1'b0, 1'b0), idle());
        chk("R9", lft_rvalid, lft_rdata, 2'b11, 16'h1111);

        // R9: different lanes from each port merge
        cyc(wr(11'd9, 16'h33AA, 1'b0, 1'b1), wr(11'd9, 16'hBB44, 1'b1, 1'b0));
        cyc(idle(), rd(11'd9, 1'b0, 1'b0));
        chk("R9", rgt_rvalid, rgt_rdata, 2'b11, 16'h3344);

        // R10: left reads while right writes the same word
        cyc(rd(11'd9, 1'b0, 1'b0), wr(11'd9, 16'h7777, 1'b0, 1'b0));
        chk("R10", lft_rvalid, lft_rdata, 2'b11, 16'h3344);

        // R8: both ports read the same word together
        cyc(rd(11'd9, 1'b0, 1'b0), rd(11'd9, 1'b0, 1'b0));
        chk("R8", lft_rvalid, lft_rdata, 2'b11, 16'h7777);
        chk("R8", rgt_rvalid, rgt_rdata, 2'b11, 16'h7777);

        // R1: reset during a read suppresses the result
        @(negedge clk);
        rst_n = 1'b0;
        lc = rd(11'd9, 1'b0, 1'b0);
        rc = rd(11'd9, 1'b0, 1'b0);
        @(negedge clk);
        chk("R1", lft_rvalid, lft_rdata, 2'b00, 16'h0000);
        chk("R1", rgt_rvalid, rgt_rdata, 2'b00, 16'h0000);
        lc = idle();
        rc = idle();
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule